// File: doc/BRIEF.md
# Byte FIFO with Threshold Control

This block is a byte-wide first-in first-out buffer meant to sit between a register bus and a serial bus engine, one instance per data direction. The producer pushes bytes and the consumer pops them. The oldest stored byte is always presented on the read data port, so a pop takes the byte that is visible at that moment. A fill level output reports how many bytes are stored.

A small configuration register holds two 8-bit threshold fields and a flush command bit. The high-threshold field drives a flag that interrupt logic can use to learn that enough data has collected. The low-threshold field is stored and read back for use by that same interrupt logic. Writing the flush bit empties the buffer at once. The full, empty and high-threshold flags are held in registers and are computed one cycle early, so they change on the same edge as the fill level.

Top module: `bytefifo_thr`

## Requirements
- R1: While and after reset, level is 0, empty is 1, full is 0, hi_flag is 0 and cfg_rdata is 0.
- R2: Bytes leave in the order they arrived. While empty is 0, pop_data shows the oldest stored byte.
- R3: A push while full (with no pop) is dropped: level stays at DEPTH (128) and the stored bytes are unchanged.
- R4: A pop while empty (with no push) is dropped: level stays 0 and empty stays 1.
- R5: A push and a pop in the same cycle leave level unchanged whenever level is between 1 and DEPTH, the full case included. When level is 0, only the push takes effect.
- R6: level is the number of stored bytes, from 0 to 128, zero-extended to 8 bits. It takes its new value on the clock edge that accepts a push or pop.
- R7: full is 1 exactly when level equals 128, and empty is 1 exactly when level equals 0.
- R8: hi_flag is 1 when the high threshold (cfg bits 15:8) is nonzero and level is at least that value. A value of 1 raises it after the first stored byte. A value of 0 keeps it at 0.
- R9: A configuration write stores bits 15:8 as the high threshold and bits 7:0 as the low threshold. cfg_rdata returns both fields in the same positions, and bit 16 reads as 0.
- R10: A configuration write with bit 16 set empties the buffer on that edge (level 0, empty 1). It wins over a push or pop in the same cycle, and its threshold fields are still loaded.
- R11: A configuration write with bit 16 clear leaves the stored bytes and level untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Store push_data this cycle |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte this cycle |
| pop_data | output | 8 | Oldest stored byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 17 | Configuration write value (bit 16 flush, 15:8 high, 7:0 low) |
| cfg_rdata | output | 17 | Configuration readback |
| level | output | 8 | Number of stored bytes |
| full | output | 1 | Buffer holds 128 bytes |
| empty | output | 1 | Buffer holds no bytes |
| hi_flag | output | 1 | Level at or above the nonzero high threshold |

## Verification
The hardest situation to reach is a push arriving while the buffer is exactly full, alone or together with a pop. This needs 128 accepted pushes with no drain in between, and uniform random traffic almost never gets there. The stimulus runs directed fill and drain sequences through that boundary. It then alternates random phases biased toward pushing and toward popping, with rare flushes and threshold rewrites, so that the full and empty edges are crossed many times while the threshold varies.

// File: rtl/bf_pkg.sv
package bf_pkg;
   localparam int unsigned THR_W     = 8;
   localparam int unsigned LO_LSB    = 0;
   localparam int unsigned HI_LSB    = 8;
   localparam int unsigned FLUSH_BIT = 16;
   localparam int unsigned CFG_W     = FLUSH_BIT + 1;

   typedef struct packed {
      logic [THR_W-1:0] hi;
      logic [THR_W-1:0] lo;
   } bf_thr_t;
endpackage

// File: rtl/bf_cfg.sv
module bf_cfg
   import bf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output bf_thr_t          thr_q,
   output bf_thr_t          thr_nxt,
   output logic             flush,
   output logic [CFG_W-1:0] cfg_rdata
);
   bf_thr_t wr_thr;

   always_comb begin
      wr_thr.hi = cfg_wdata[HI_LSB +: THR_W];
      wr_thr.lo = cfg_wdata[LO_LSB +: THR_W];
      thr_nxt   = cfg_we ? wr_thr : thr_q;
      flush     = cfg_we & cfg_wdata[FLUSH_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= '0;
      else        thr_q <= thr_nxt;
   end

   always_comb begin
      cfg_rdata                   = '0;
      cfg_rdata[HI_LSB +: THR_W]  = thr_q.hi;
      cfg_rdata[LO_LSB +: THR_W]  = thr_q.lo;
   end

   p_thr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata[HI_LSB +: THR_W] == $past(cfg_wdata[HI_LSB +: THR_W]))
              && (cfg_rdata[LO_LSB +: THR_W] == $past(cfg_wdata[LO_LSB +: THR_W])));

   p_flush_bit_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata[FLUSH_BIT] == 1'b0));
endmodule

// File: rtl/bf_ptr_ctrl.sv
module bf_ptr_ctrl #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned PTR_W = $clog2(DEPTH),
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             flush,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             full,
   output logic             empty
);
   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic             take_pop, take_push;
   logic [PTR_W-1:0] wr_inc, rd_inc;

   generate
      if (IS_POW2) begin : g_pow2_wrap
         assign wr_inc = wr_ptr + PTR_W'(1);
         assign rd_inc = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      take_pop  = pop_req & ~empty & ~flush;
      take_push = push_req & (~full | (pop_req & ~empty)) & ~flush;
      wr_en     = take_push;
      if (flush) begin
         cnt_nxt = '0;
      end else begin
         unique case ({take_push, take_pop})
            2'b10:   cnt_nxt = count + CNT_W'(1);
            2'b01:   cnt_nxt = count - CNT_W'(1);
            default: cnt_nxt = count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         full   <= 1'b0;
         empty  <= 1'b1;
      end else begin
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (take_push) wr_ptr <= wr_inc;
            if (take_pop)  rd_ptr <= rd_inc;
         end
         count <= cnt_nxt;
         full  <= (cnt_nxt == CNT_W'(DEPTH));
         empty <= (cnt_nxt == '0);
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !pop_req && !flush) |=> (count == CNT_W'(DEPTH)) && $stable(wr_ptr));

   p_empty_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req && !flush) |=> (count == '0) && $stable(rd_ptr));

   p_pair_keeps_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && push_req && pop_req && !flush) |=> $stable(count));

   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty && (count == '0) && (wr_ptr == rd_ptr));

   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/bf_store.sv
module bf_store #(
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/bf_level_flag.sv
module bf_level_flag #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [THR_W-1:0] thr_nxt,
   input  logic [CNT_W-1:0] count,
   input  logic [THR_W-1:0] thr_q,
   output logic             flag_q
);
   localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

   logic flag_d;

   always_comb begin
      flag_d = (thr_nxt != '0) && (CMP_W'(cnt_nxt) >= CMP_W'(thr_nxt));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   p_hi_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q == ((thr_q != '0) && (CMP_W'(count) >= CMP_W'(thr_q))));
endmodule

// File: rtl/bytefifo_thr.sv
module bytefifo_thr
   import bf_pkg::*;
#(
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LVL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty,
   output logic              hi_flag
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("bytefifo_thr: DEPTH must be at least 2");
      end
      if (DEPTH >= (1 << LVL_W)) begin : g_bad_lvl
         $error("bytefifo_thr: LVL_W too narrow for DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("bytefifo_thr: DATA_W must be positive");
      end
   endgenerate

   bf_thr_t          thr_q, thr_nxt;
   logic             flush, wr_en;
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count, cnt_nxt;

   bf_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .thr_q     (thr_q),
      .thr_nxt   (thr_nxt),
      .flush     (flush),
      .cfg_rdata (cfg_rdata)
   );

   bf_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push),
      .pop_req  (pop),
      .flush    (flush),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .count    (count),
      .cnt_nxt  (cnt_nxt),
      .full     (full),
      .empty    (empty)
   );

   bf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_ptr  (wr_ptr),
      .wr_data (push_data),
      .rd_ptr  (rd_ptr),
      .rd_data (pop_data)
   );

   bf_level_flag #(.CNT_W(CNT_W), .THR_W(THR_W)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt),
      .thr_nxt (thr_nxt.hi),
      .count   (count),
      .thr_q   (thr_q.hi),
      .flag_q  (hi_flag)
   );

   assign level = LVL_W'(count);

   p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full == (level == LVL_W'(DEPTH)));

   p_empty_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (level == '0));

   p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (level == $past(level)) || (level == $past(level) + LVL_W'(1))
                 || (level == $past(level) - LVL_W'(1)));

   p_plain_cfg_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[FLUSH_BIT] && !push && !pop) |=> $stable(level));
endmodule

// File: tb/bytefifo_thr_tb.sv
`timescale 1ns/1ps
module bytefifo_thr_tb;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push = 1'b0, pop = 1'b0, cfg_we = 1'b0;
   logic [7:0]  push_data = '0;
   logic [16:0] cfg_wdata = '0;
   logic [7:0]  pop_data, level;
   logic [16:0] cfg_rdata;
   logic        full, empty, hi_flag;

   int total = 0;
   int bad = 0;

   logic [7:0] q[$];
   logic [7:0] m_hi = '0, m_lo = '0;

   always #2.5 clk = ~clk;

   bytefifo_thr u_dut (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
      .pop_data(pop_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .level(level), .full(full), .empty(empty), .hi_flag(hi_flag)
   );

   function automatic logic exp_hi(input int n, input logic [7:0] thr);
      return (thr != 0) && (n >= int'(thr));
   endfunction

   function automatic logic [16:0] exp_cfg(input logic [7:0] h, input logic [7:0] l);
      return {1'b0, h, l};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R6 level", 32'(level), 32'(q.size()));
      chk("R7 full", 32'(full), 32'(q.size() == DEPTH));
      chk("R7 empty", 32'(empty), 32'(q.size() == 0));
      chk("R8 hi_flag", 32'(hi_flag), 32'(exp_hi(q.size(), m_hi)));
      chk("R9 cfg_rdata", 32'(cfg_rdata), 32'(exp_cfg(m_hi, m_lo)));
      if (q.size() > 0) chk("R2 pop_data", 32'(pop_data), 32'(q[0]));
   endtask

   task automatic tick(input logic p, input logic [7:0] d, input logic o,
                       input logic we, input logic [16:0] wd);
      logic did_pop;
      push = p; push_data = d; pop = o; cfg_we = we; cfg_wdata = wd;
      @(posedge clk);
      #1;
      if (we && wd[16]) begin
         q.delete();
      end else begin
         did_pop = o && (q.size() > 0);
         if (p && (q.size() < DEPTH || did_pop)) begin
            if (did_pop) void'(q.pop_front());
            q.push_back(d);
         end else if (did_pop) begin
            void'(q.pop_front());
         end
      end
      if (we) begin m_hi = wd[15:8]; m_lo = wd[7:0]; end
      push = 0; pop = 0; cfg_we = 0;
      check_all();
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 level", 32'(level), 0);
      chk("R1 empty", 32'(empty), 1);
      chk("R1 full", 32'(full), 0);
      chk("R1 hi_flag", 32'(hi_flag), 0);
      chk("R1 cfg_rdata", 32'(cfg_rdata), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R9 and R8: high threshold of 1 fires on the first byte
      tick(0, 0, 0, 1, {1'b0, 8'd1, 8'd5});
      chk("R9 readback", 32'(cfg_rdata), 32'h0105);
      chk("R8 thr1 before", 32'(hi_flag), 0);
      tick(1, 8'hA5, 0, 0, 0);
      chk("R8 thr1 first byte", 32'(hi_flag), 1);

      // fill to full, then R3 push when full
      for (int i = 0; i < DEPTH - 1; i++) tick(1, 8'($urandom), 0, 0, 0);
      chk("R7 full at 128", 32'(full), 1);
      tick(1, 8'hEE, 0, 0, 0);
      chk("R3 level held", 32'(level), DEPTH);
      chk("R3 head intact", 32'(pop_data), 32'h00A5);
      // R5 push+pop while full
      tick(1, 8'h3C, 1, 0, 0);
      chk("R5 full pair level", 32'(level), DEPTH);

      // R11 plain config write keeps contents
      tick(0, 0, 0, 1, {1'b0, 8'd200, 8'd7});
      chk("R11 level kept", 32'(level), DEPTH);
      chk("R8 thr200 below", 32'(hi_flag), 0);

      // drain, R2 order checked each cycle
      while (q.size() > 0) tick(0, 0, 1, 0, 0);
      // R4 pop when empty
      tick(0, 0, 1, 0, 0);
      chk("R4 level zero", 32'(level), 0);
      chk("R4 empty held", 32'(empty), 1);
      // R5 pair when empty: push only
      tick(1, 8'h5A, 1, 0, 0);
      chk("R5 empty pair level", 32'(level), 1);
      chk("R5 empty pair data", 32'(pop_data), 32'h5A);

      // R10 flush beats a same-cycle push, loads thresholds
      tick(1, 8'h11, 0, 0, 0);
      tick(1, 8'h22, 0, 1, {1'b1, 8'd3, 8'd9});
      chk("R10 level", 32'(level), 0);
      chk("R10 empty", 32'(empty), 1);
      chk("R10 bit reads 0", 32'(cfg_rdata), 32'h0309);

      // random phases biased toward filling or draining
      for (int ph = 0; ph < 24; ph++) begin
         int bias = (ph % 2 == 0) ? 85 : 20;
         for (int c = 0; c < 300; c++) begin
            logic p, o, we;
            logic [16:0] wd;
            p  = ($urandom % 100) < bias;
            o  = ($urandom % 100) < (100 - bias);
            we = ($urandom % 64) == 0;
            wd = {($urandom % 4) == 0, 8'($urandom % 140), 8'($urandom)};
            tick(p, 8'($urandom), o, we, wd);
         end
      end
      finish_run();
   end
endmodule